// File: doc/BRIEF.md
# Floating-Point Compare and Condition-Flag Unit

This unit compares two IEEE-754 operands and stores a single-bit verdict in one of a bank of condition flags. The operands arrive in 64-bit registers. A precision select chooses double precision or single precision. In single precision only the low 32 bits of each operand take part. A 5-bit condition code selects the predicate, and a 3-bit index selects the flag that receives the verdict.

Each predicate is built from four relation bits: less-than, equal, greater-than and unordered. Every pair of adjacent condition codes shares one relation mask. The even code is the quiet form and the odd code is the signaling form. The two forms differ only in when the sticky invalid-operation status bit is raised. Some condition codes are reserved. A reserved code writes nothing and produces a one-cycle illegal indication. The unit is intended to sit behind an instruction decoder, which supplies the code, the index and a valid strobe for each compare.

Top module: `fcmp_flag_unit`

## Requirements
- R1: After a synchronous reset, all eight condition flags, the invalid status and the illegal indication are 0.
- R2: The verdict is the OR of the relations enabled by `cond_i[4:1]`. The masks are: 0 none, 1 LT, 2 EQ, 3 LT|EQ, 4 UN, 5 UN|LT, 6 UN|EQ, 7 UN|LT|EQ, 8 LT|GT, 10 LT|GT|EQ, 12 UN|LT|GT. LT means a<b and GT means b<a.
- R3: If either operand is a NaN, LT, EQ and GT are all false and UN is true. Exactly one relation holds for any operand pair. +0 and -0 compare equal.
- R4: Ordering follows sign and magnitude, so negative values order below positive ones and a larger negative magnitude is the smaller value. This holds in both precisions.
- R5: With `dbl_i`=0, only bits 31:0 of each operand are compared as single-precision values. Bits 63:32 have no effect.
- R6: Condition codes 18, 19, 22, 23 and 26..31 are illegal. Such a code changes no flag and does not raise the invalid status, and `illegal_o` is 1 in the following cycle.
- R7: The verdict appears on `flags_o[flag_idx_i]` one clock after `valid_i`. No other flag changes, and without `valid_i` no flag changes.
- R8: For a legal code, the invalid status is raised in the following cycle when either operand is a NaN (signaling form, `cond_i[0]`=1) or when either operand is a signaling NaN (quiet form, `cond_i[0]`=0). A signaling NaN has an all-ones exponent, a nonzero fraction and a fraction MSB of 0. This applies to the always-false codes 0 and 1 as well.
- R9: The invalid status is sticky and is cleared only by `clr_inv_i`. If a compare in the same cycle raises it, the status still ends up set.
- R10: `illegal_o` is high for exactly one cycle per illegal strobe and is low in any cycle not preceded by an illegal strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Compare request strobe |
| dbl_i | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| cond_i | input | 5 | Condition code; bit 0 selects the signaling form |
| flag_idx_i | input | 3 | Index of the flag to write |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| clr_inv_i | input | 1 | Clears the sticky invalid status |
| flags_o | output | 8 | Condition flag bank |
| invalid_o | output | 1 | Sticky invalid-operation status |
| illegal_o | output | 1 | One-cycle pulse after an illegal condition code |

## Verification
Every result is due exactly one clock after its stimulus: the flag write, the invalid-status update and the illegal pulse are all registered on the first rising edge that sees `valid_i` or `clr_inv_i`. The bench drives inputs on a falling edge and drops the strobe on the next falling edge. It samples all outputs at that point, half a cycle after the capturing rising edge. After each illegal strobe the bench waits one more idle cycle and confirms that `illegal_o` has returned low and that the flag bank has not moved.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int MAG_W  = 63;
    localparam int SP_EXP = 8;
    localparam int SP_MAN = 23;
    localparam int DP_EXP = 11;
    localparam int DP_MAN = 52;

    typedef struct packed {
        logic un;
        logic gt;
        logic eq;
        logic lt;
    } rel_t;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef struct packed {
        logic legal;
        rel_t en;
    } cond_dec_t;

    function automatic cond_dec_t decode_cond(input logic [4:0] code);
        cond_dec_t d;
        d.legal = 1'b1;
        d.en    = '0;
        unique case (code[4:1])
            4'd0:  d.en = '0;
            4'd1:  d.en.lt = 1'b1;
            4'd2:  d.en.eq = 1'b1;
            4'd3:  begin d.en.lt = 1'b1; d.en.eq = 1'b1; end
            4'd4:  d.en.un = 1'b1;
            4'd5:  begin d.en.un = 1'b1; d.en.lt = 1'b1; end
            4'd6:  begin d.en.un = 1'b1; d.en.eq = 1'b1; end
            4'd7:  begin d.en.un = 1'b1; d.en.lt = 1'b1; d.en.eq = 1'b1; end
            4'd8:  begin d.en.lt = 1'b1; d.en.gt = 1'b1; end
            4'd10: begin d.en.lt = 1'b1; d.en.gt = 1'b1; d.en.eq = 1'b1; end
            4'd12: begin d.en.un = 1'b1; d.en.lt = 1'b1; d.en.gt = 1'b1; end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int MAN_W = 52
) (
    input  logic [EXP_W+MAN_W:0] raw_i,
    output opnd_t                cls_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    always_comb begin
        expo          = raw_i[W-2:MAN_W];
        frac          = raw_i[MAN_W-1:0];
        cls_o.sign    = raw_i[W-1];
        cls_o.nan     = (&expo) && (|frac);
        cls_o.snan    = (&expo) && (|frac) && !frac[MAN_W-1];
        cls_o.zero    = ~|raw_i[W-2:0];
        cls_o.mag     = MAG_W'(raw_i[W-2:0]);
    end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_t  rel_o
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a_i.mag < b_i.mag;
        mag_eq = a_i.mag == b_i.mag;
        rel_o  = '0;
        if (a_i.nan || b_i.nan) begin
            rel_o.un = 1'b1;
        end else if (a_i.zero && b_i.zero) begin
            rel_o.eq = 1'b1;
        end else if (a_i.sign != b_i.sign) begin
            rel_o.lt = a_i.sign;
            rel_o.gt = b_i.sign;
        end else if (mag_eq) begin
            rel_o.eq = 1'b1;
        end else begin
            rel_o.lt = a_i.sign ? !mag_lt : mag_lt;
            rel_o.gt = a_i.sign ? mag_lt : !mag_lt;
        end
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic                 dbl_i,
    input  logic [4:0]           cond_i,
    input  logic [IDX_W-1:0]     flag_idx_i,
    input  logic [DATA_W-1:0]    opa_i,
    input  logic [DATA_W-1:0]    opb_i,
    input  logic                 clr_inv_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 invalid_o,
    output logic                 illegal_o
);
    localparam int SP_W = 1 + SP_EXP + SP_MAN;
    localparam int DP_W = 1 + DP_EXP + DP_MAN;

    logic [DATA_W-1:0] raw [2];
    opnd_t             cls_sp [2];
    opnd_t             cls_dp [2];
    opnd_t             cls    [2];
    rel_t              rel;
    cond_dec_t         dec;
    logic              hit;
    logic              inv_set;

    assign raw[0] = opa_i;
    assign raw[1] = opb_i;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        fcmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
            .raw_i (raw[g][SP_W-1:0]),
            .cls_o (cls_sp[g])
        );
        fcmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
            .raw_i (raw[g][DP_W-1:0]),
            .cls_o (cls_dp[g])
        );
        assign cls[g] = dbl_i ? cls_dp[g] : cls_sp[g];
    end

    fcmp_relate u_rel (
        .a_i   (cls[0]),
        .b_i   (cls[1]),
        .rel_o (rel)
    );

    always_comb begin
        dec     = decode_cond(cond_i);
        hit     = |(dec.en & rel);
        inv_set = cond_i[0] ? (cls[0].nan  || cls[1].nan)
                            : (cls[0].snan || cls[1].snan);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o   <= '0;
            invalid_o <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            illegal_o <= valid_i && !dec.legal;
            invalid_o <= (clr_inv_i ? 1'b0 : invalid_o)
                       | (valid_i && dec.legal && inv_set);
            if (valid_i && dec.legal) begin
                flags_o[flag_idx_i] <= hit;
            end
        end
    end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 valid_i,
    input logic [4:0]           cond_i,
    input logic [IDX_W-1:0]     flag_idx_i,
    input logic                 clr_inv_i,
    input logic [NUM_FLAGS-1:0] flags_o,
    input logic                 invalid_o,
    input logic                 illegal_o,
    input logic [3:0]           rel_bits,
    input logic                 a_nan,
    input logic                 b_nan
);
    logic code_ok;
    assign code_ok = (cond_i < 5'd26) && (cond_i != 5'd18) && (cond_i != 5'd19)
                   && (cond_i != 5'd22) && (cond_i != 5'd23);

    // R7: no strobe, no flag movement
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(flags_o));

    // R7: only the addressed flag may change
    assert_one_flag_R7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> ((flags_o ^ $past(flags_o))
                     & ~(NUM_FLAGS'(1) << $past(flag_idx_i))) == '0);

    // R6: illegal code writes nothing and is reported
    assert_illegal_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        valid_i && !code_ok && !clr_inv_i |=> $stable(flags_o) && illegal_o && $stable(invalid_o));

    // R10: illegal pulse only after an illegal strobe
    assert_illegal_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && !code_ok) |=> !illegal_o);

    // R9: sticky until cleared
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        invalid_o && !clr_inv_i |=> invalid_o);

    // R9: a clear without a compare empties the status
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr_inv_i && !valid_i |=> !invalid_o);

    // R3: exactly one relation holds
    assert_rel_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(rel_bits) == 1);

    // R3: a NaN operand means unordered
    assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (rst)
        (a_nan || b_nan) |-> rel_bits[3]);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .cond_i     (cond_i),
    .flag_idx_i (flag_idx_i),
    .clr_inv_i  (clr_inv_i),
    .flags_o    (flags_o),
    .invalid_o  (invalid_o),
    .illegal_o  (illegal_o),
    .rel_bits   (rel),
    .a_nan      (cls[0].nan),
    .b_nan      (cls[1].nan)
);

// File: tb/tb_fcmp_flag_unit.sv
module tb_fcmp_flag_unit;
    localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_P2   = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_M1   = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] D_PZ   = 64'h0000_0000_0000_0000;
    localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [31:0] S_P1   = 32'h3F80_0000;
    localparam logic [31:0] S_P2   = 32'h4000_0000;
    localparam logic [31:0] S_M1   = 32'hBF80_0000;
    localparam logic [31:0] S_M2   = 32'hC000_0000;
    localparam logic [31:0] S_SNAN = 32'h7F80_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic        dbl_i = 1'b1;
    logic [4:0]  cond_i = '0;
    logic [2:0]  flag_idx_i = '0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        clr_inv_i = 1'b0;
    logic [7:0]  flags_o;
    logic        invalid_o;
    logic        illegal_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_flags = '0;
    logic       exp_inv = 1'b0;

    always #5 clk = ~clk;

    fcmp_flag_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .dbl_i(dbl_i), .cond_i(cond_i),
        .flag_idx_i(flag_idx_i), .opa_i(opa_i), .opb_i(opb_i), .clr_inv_i(clr_inv_i),
        .flags_o(flags_o), .invalid_o(invalid_o), .illegal_o(illegal_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic exp_ill);
        check({tag, " flags"}, 64'(flags_o), 64'(exp_flags));
        check({tag, " invalid"}, 64'(invalid_o), 64'(exp_inv));
        check({tag, " illegal"}, 64'(illegal_o), 64'(exp_ill));
    endtask

    task automatic run(input string tag, input logic dbl, input logic [4:0] cond,
                       input logic [2:0] idx, input logic [63:0] a, input logic [63:0] b,
                       input logic res, input logic set, input logic ill, input logic clr);
        @(negedge clk);
        dbl_i = dbl; cond_i = cond; flag_idx_i = idx; opa_i = a; opb_i = b;
        valid_i = 1'b1; clr_inv_i = clr;
        @(negedge clk);
        valid_i = 1'b0; clr_inv_i = 1'b0;
        if (clr) exp_inv = 1'b0;
        if (!ill) begin
            exp_flags[idx] = res;
            exp_inv = exp_inv | set;
        end
        check_all(tag, ill);
    endtask

    task automatic clear_inv(input string tag);
        @(negedge clk);
        clr_inv_i = 1'b1;
        @(negedge clk);
        clr_inv_i = 1'b0;
        exp_inv = 1'b0;
        check_all(tag, 1'b0);
    endtask

    task automatic t_reset;
        check_all("R1 reset", 1'b0);
    endtask

    task automatic t_predicates;
        run("R2 lt 1<2",      1, 5'd2,  3'd0, D_P1, D_P2, 1, 0, 0, 0);
        run("R2 ne 2,1",      1, 5'd16, 3'd1, D_P2, D_P1, 1, 0, 0, 0);
        run("R2 eq 1,1",      1, 5'd4,  3'd2, D_P1, D_P1, 1, 0, 0, 0);
        run("R2 le 2,1",      1, 5'd6,  3'd2, D_P2, D_P1, 0, 0, 0, 0);
        run("R2 or 1,1",      1, 5'd20, 3'd3, D_P1, D_P1, 1, 0, 0, 0);
        run("R2 une qnan",    1, 5'd24, 3'd4, D_QNAN, D_P1, 1, 0, 0, 0);
        run("R2 un 1,2",      1, 5'd8,  3'd4, D_P1, D_P2, 0, 0, 0, 0);
        run("R2 false 1,1",   1, 5'd0,  3'd3, D_P1, D_P1, 0, 0, 0, 0);
    endtask

    task automatic t_special;
        run("R3 +0 eq -0",    1, 5'd4,  3'd5, D_PZ, D_NZ, 1, 0, 0, 0);
        run("R3 or qnan",     1, 5'd20, 3'd5, D_QNAN, D_P1, 0, 0, 0, 0);
        run("R3 ueq qnan",    1, 5'd12, 3'd6, D_P1, D_QNAN, 1, 0, 0, 0);
        run("R3 lt nan,nan",  1, 5'd2,  3'd6, D_QNAN, D_QNAN, 0, 0, 0, 0);
    endtask

    task automatic t_order;
        run("R4 -1<1",        1, 5'd2,  3'd7, D_M1, D_P1, 1, 0, 0, 0);
        run("R4 sp -1<-2",    0, 5'd2,  3'd0, {32'h0, S_M1}, {32'h0, S_M2}, 0, 0, 0, 0);
        run("R4 sp -2<-1",    0, 5'd10, 3'd0, {32'h0, S_M2}, {32'h0, S_M1}, 1, 0, 0, 0);
        run("R4 ne -1,-1",    1, 5'd16, 3'd7, D_M1, D_M1, 0, 0, 0, 0);
    endtask

    task automatic t_single;
        run("R5 upper nan ignored", 0, 5'd2, 3'd1, {32'h7FF8_0000, S_P1}, {32'h0, S_P2}, 1, 0, 0, 0);
        run("R5 upper differ eq",   0, 5'd4, 3'd1, {32'hFFFF_FFFF, S_P2}, {32'h1234_5678, S_P2}, 1, 0, 0, 0);
    endtask

    task automatic t_illegal;
        foreach (exp_flags[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [4:0] c;
            c = (k == 0) ? 5'd18 : (k == 1) ? 5'd23 : (k == 2) ? 5'd26 : 5'd31;
            run("R6 illegal code", 1, c, 3'd2, D_SNAN, D_P1, 1, 1, 1, 0);
            @(negedge clk);
            check_all("R10 illegal drops", 1'b0);
        end
    endtask

    task automatic t_except;
        run("R8 caf snan sets",     1, 5'd0,  3'd3, D_SNAN, D_P1, 0, 1, 0, 0);
        clear_inv("R9 clear");
        run("R8 saf qnan sets",     1, 5'd1,  3'd3, D_QNAN, D_P1, 0, 1, 0, 0);
        clear_inv("R9 clear again");
        run("R8 ceq qnan quiet",    1, 5'd4,  3'd3, D_QNAN, D_QNAN, 0, 0, 0, 0);
        run("R8 seq ordered",       1, 5'd5,  3'd3, D_P1, D_P1, 1, 0, 0, 0);
        run("R8 sun qnan",          1, 5'd9,  3'd4, D_QNAN, D_P2, 1, 1, 0, 0);
        run("R9 still set",         1, 5'd2,  3'd5, D_P1, D_P2, 1, 0, 0, 0);
        run("R9 clr with quiet op", 1, 5'd0,  3'd5, D_P1, D_P1, 0, 0, 0, 1);
        run("R9 clr loses to set",  1, 5'd2,  3'd6, D_SNAN, D_P1, 0, 1, 0, 1);
        clear_inv("R9 clear final");
        run("R8 sp cun snan",       0, 5'd8,  3'd7, {32'h0, S_SNAN}, {32'h0, S_P1}, 1, 1, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_predicates();
        t_special();
        t_order();
        t_single();
        t_illegal();
        t_except();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule